// File: doc/BRIEF.md
# Programmable Wait-State Memory Select Unit

This unit sits between a processor's external bus sequencer and the memories attached to it. When the sequencer presents a request together with an address space (program, data, byte or I/O), the unit drives the matching active-low select strobe. It also drives a composite select that can stand in for any chosen group of spaces, so that one physical memory can answer in more than one space. Every access is stretched by a programmable number of wait states. A ready flag stays low while the access is stalled.

The stall length comes from a 4-bit field per space. The I/O space has four such fields, one for each quarter of its 2048-word range, chosen by the two top address bits. A global mode bit turns a field value N into 2N+1 wait states instead of N. A byte-strobe disable bit removes the byte-space strobe, so that byte accesses reach only the memory wired to the composite select. All settings are written through a small register port. An access uses the settings present when it starts.

Top module: `wsel_unit`

## Requirements
- R1: After reset all four strobes `sel_n` are high, `csel_n` is high and `ready` is high. Every field resets to 15, the mode bit and the byte disable bit reset to 0, and the composite mask resets to 4'b1011.
- R2: For an I/O access the wait field is chosen by `io_addr[10:9]`: 0 selects region 0 (0x000–0x1FF), and so on up to 3 for region 3 (0x600–0x7FF). Region fields are written at `cfg_addr` 0 to 3.
- R3: With the mode bit clear, a field value N gives N wait states. The strobe is low for N+1 cycles starting on the edge that accepts `req`, `ready` is low for the first N of them, and the strobe returns high on the edge after the cycle in which `ready` is high.
- R4: With the mode bit set (`cfg_addr` 8, data bit 0), a field value N gives 2N+1 wait states.
- R5: Program, data and byte spaces (`space` codes 0, 1 and 2; I/O is 3) each use their own field, written at `cfg_addr` 4, 5 and 6.
- R6: `csel_n` is low exactly in the cycles when the access strobe is timed low, and only if the mask bit for the accessed space is set. The mask is written at `cfg_addr` 9, with bit 0 for program, 1 for data, 2 for byte and 3 for I/O.
- R7: With the reset mask, a byte access drives `sel_n[2]` low and leaves `csel_n` high.
- R8: With byte disable set (`cfg_addr` 8, data bit 1), a byte access leaves all of `sel_n` high. The access keeps its full timing on `ready`, and `csel_n` still follows the mask.
- R9: A configuration write made while an access is in progress does not change that access. It applies from the next access onward.
- R10: A `req` that arrives while an access is in progress is ignored.
- R11: At most one bit of `sel_n` is low in any cycle. `sel_n[k]` belongs to space code k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, accepted when idle |
| space | input | 2 | Space code: 0 program, 1 data, 2 byte, 3 I/O |
| io_addr | input | 11 | I/O word address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_data | input | 4 | Configuration write data |
| sel_n | output | 4 | Active-low per-space select strobes |
| csel_n | output | 1 | Active-low composite select |
| ready | output | 1 | Low while the current access is stalled |

## Verification
A request driven before a rising edge is accepted on that edge. The strobes, composite select and ready take their first access values just after that edge, and then hold for exactly W+1 edges, where W is the expected wait count. The strobes return high one edge after the cycle in which ready is seen high. The driver turns each access into one expected entry per clock edge, and the monitor samples a quarter period after each rising edge and compares against the head of that queue. When the queue is empty, the monitor expects idle outputs, which checks the release edge and the cycles between accesses. Configuration writes and ignored requests are placed inside a running access, and they must leave the queued values for that access unchanged.

// File: rtl/wsel_pkg.sv
package wsel_pkg;
   typedef enum logic [1:0] {
      SP_PROG = 2'd0,
      SP_DATA = 2'd1,
      SP_BYTE = 2'd2,
      SP_IO   = 2'd3
   } space_e;

   localparam int NSPACE = 4;

   // configuration register select codes
   localparam logic [3:0] CA_PROG = 4'd4;
   localparam logic [3:0] CA_DATA = 4'd5;
   localparam logic [3:0] CA_BYTE = 4'd6;
   localparam logic [3:0] CA_CTRL = 4'd8;
   localparam logic [3:0] CA_MASK = 4'd9;

   localparam logic [NSPACE-1:0] MASK_RST = 4'b1011;
endpackage

// File: rtl/wsel_cfg.sv
module wsel_cfg
   import wsel_pkg::*;
#(
   parameter int NREGION = 4,
   parameter int WAIT_W  = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_we,
   input  logic [3:0]                       cfg_addr,
   input  logic [WAIT_W-1:0]                cfg_data,
   output logic [NREGION-1:0][WAIT_W-1:0]   io_wait,
   output logic [WAIT_W-1:0]                prog_wait,
   output logic [WAIT_W-1:0]                data_wait,
   output logic [WAIT_W-1:0]                byte_wait,
   output logic                             dbl_mode,
   output logic                             byte_off,
   output logic [NSPACE-1:0]                cmask
);
   initial begin
      if (NREGION > 4) $error("wsel_cfg: region fields share codes 0..3");
      if (WAIT_W < NSPACE) $error("wsel_cfg: data width too narrow for mask");
   end

   for (genvar g = 0; g < NREGION; g++) begin : g_rgn
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               io_wait[g] <= '1;
         else if (cfg_we && cfg_addr == 4'(g))     io_wait[g] <= cfg_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_wait <= '1;
         data_wait <= '1;
         byte_wait <= '1;
         dbl_mode  <= 1'b0;
         byte_off  <= 1'b0;
         cmask     <= MASK_RST;
      end else if (cfg_we) begin
         case (cfg_addr)
            CA_PROG: prog_wait <= cfg_data;
            CA_DATA: data_wait <= cfg_data;
            CA_BYTE: byte_wait <= cfg_data;
            CA_CTRL: begin
               dbl_mode <= cfg_data[0];
               byte_off <= cfg_data[1];
            end
            CA_MASK: cmask <= cfg_data[NSPACE-1:0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/wsel_calc.sv
module wsel_calc
   import wsel_pkg::*;
#(
   parameter int NREGION = 4,
   parameter int WAIT_W  = 4,
   parameter int IO_AW   = 11,
   localparam int RGN_W  = $clog2(NREGION),
   localparam int CNT_W  = WAIT_W + 1
) (
   input  logic [1:0]                       space,
   input  logic [IO_AW-1:0]                 io_addr,
   input  logic [NREGION-1:0][WAIT_W-1:0]   io_wait,
   input  logic [WAIT_W-1:0]                prog_wait,
   input  logic [WAIT_W-1:0]                data_wait,
   input  logic [WAIT_W-1:0]                byte_wait,
   input  logic                             dbl_mode,
   output logic [CNT_W-1:0]                 wcount
);
   logic [WAIT_W-1:0] rgn_field;
   logic [WAIT_W-1:0] field;

   generate
      if (NREGION > 1) begin : g_multi
         logic [RGN_W-1:0] rgn;
         assign rgn       = io_addr[IO_AW-1 -: RGN_W];
         assign rgn_field = io_wait[rgn];
      end else begin : g_single
         assign rgn_field = io_wait[0];
      end
   endgenerate

   always_comb begin
      case (space_e'(space))
         SP_PROG: field = prog_wait;
         SP_DATA: field = data_wait;
         SP_BYTE: field = byte_wait;
         default: field = rgn_field;
      endcase
   end

   // 2N+1 is N shifted left with a one in the low bit
   assign wcount = dbl_mode ? {field, 1'b1} : {1'b0, field};
endmodule

// File: rtl/wsel_seq.sv
module wsel_seq
   import wsel_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [1:0]         space,
   input  logic [CNT_W-1:0]   wcount,
   input  logic               byte_off,
   input  logic [NSPACE-1:0]  cmask,
   output logic [NSPACE-1:0]  sel_n,
   output logic               csel_n,
   output logic               ready,
   output logic               acc_on,
   output logic [CNT_W-1:0]   cnt_q
);
   logic [NSPACE-1:0] strobe_q;
   logic              comp_q;
   logic [NSPACE-1:0] strobe_d;

   always_comb begin
      strobe_d = NSPACE'(1) << space;
      if (byte_off) strobe_d[SP_BYTE] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_on   <= 1'b0;
         cnt_q    <= '0;
         strobe_q <= '0;
         comp_q   <= 1'b0;
      end else if (!acc_on) begin
         if (req) begin
            acc_on   <= 1'b1;
            cnt_q    <= wcount;
            strobe_q <= strobe_d;
            comp_q   <= cmask[space];
         end
      end else if (cnt_q == '0) begin
         acc_on   <= 1'b0;
         strobe_q <= '0;
         comp_q   <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign sel_n  = ~strobe_q;
   assign csel_n = ~comp_q;
   assign ready  = !(acc_on && cnt_q != '0);
endmodule

// File: rtl/wsel_unit.sv
module wsel_unit
   import wsel_pkg::*;
#(
   parameter int NREGION = 4,
   parameter int WAIT_W  = 4,
   parameter int IO_AW   = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req,
   input  logic [1:0]         space,
   input  logic [IO_AW-1:0]   io_addr,
   input  logic               cfg_we,
   input  logic [3:0]         cfg_addr,
   input  logic [WAIT_W-1:0]  cfg_data,
   output logic [NSPACE-1:0]  sel_n,
   output logic               csel_n,
   output logic               ready
);
   localparam int CNT_W = WAIT_W + 1;
   localparam int RGN_W = $clog2(NREGION);

   initial begin
      if (IO_AW <= RGN_W) $error("wsel_unit: I/O address narrower than region index");
      if ((1 << RGN_W) != NREGION) $error("wsel_unit: region count must be a power of two");
   end

   logic [NREGION-1:0][WAIT_W-1:0] io_wait;
   logic [WAIT_W-1:0]              prog_wait, data_wait, byte_wait;
   logic                           dbl_mode, byte_off;
   logic [NSPACE-1:0]              cmask;
   logic [CNT_W-1:0]               wcount;
   logic                           acc_on;
   logic [CNT_W-1:0]               cnt_q;

   wsel_cfg #(.NREGION(NREGION), .WAIT_W(WAIT_W)) u_cfg (
      .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_data,
      .io_wait, .prog_wait, .data_wait, .byte_wait,
      .dbl_mode, .byte_off, .cmask
   );

   wsel_calc #(.NREGION(NREGION), .WAIT_W(WAIT_W), .IO_AW(IO_AW)) u_calc (
      .space, .io_addr, .io_wait, .prog_wait, .data_wait, .byte_wait,
      .dbl_mode, .wcount
   );

   wsel_seq #(.CNT_W(CNT_W)) u_seq (
      .clk, .rst_n, .req, .space, .wcount, .byte_off, .cmask,
      .sel_n, .csel_n, .ready, .acc_on, .cnt_q
   );
endmodule

// File: rtl/wsel_unit_chk.sv
module wsel_unit_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       sel_n,
   input logic             csel_n,
   input logic             ready,
   input logic             acc_on,
   input logic [CNT_W-1:0] cnt_q
);
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n)); // R11

   AST_CS_STARTS_WITH_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(csel_n) |-> $rose(acc_on)); // R6

   AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_on && !ready) |=> (acc_on && $stable(sel_n) && $stable(csel_n))); // R3

   AST_RELEASE_AFTER_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_on && ready) |=> (!acc_on && sel_n == 4'hF && csel_n)); // R3

   AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_on && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_on |-> (sel_n == 4'hF && csel_n && ready)); // R1
endmodule

bind wsel_unit wsel_unit_chk #(.CNT_W(WAIT_W + 1)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .csel_n(csel_n),
   .ready(ready), .acc_on(acc_on), .cnt_q(cnt_q)
);

// File: tb/wsel_unit_bench.sv
module wsel_unit_bench;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0;
   logic [1:0]  space = 2'd0;
   logic [10:0] io_addr = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [3:0]  cfg_data = '0;
   logic [3:0]  sel_n;
   logic        csel_n;
   logic        ready;

   always #(CLK_P/2) clk = ~clk;

   wsel_unit u_wsel_unit (
      .clk, .rst_n, .req, .space, .io_addr, .cfg_we, .cfg_addr, .cfg_data,
      .sel_n, .csel_n, .ready
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   // scoreboard: one entry {sel_n, csel_n, ready} per rising edge
   logic [5:0] exp_q[$];
   string      tag_q[$];

   // bench's own copy of the configuration
   logic [3:0] sh_io [4];
   logic [3:0] sh_prog = 4'hF, sh_data = 4'hF, sh_byte = 4'hF;
   logic       sh_mode = 1'b0, sh_boff = 1'b0;
   logic [3:0] sh_mask = 4'b1011;

   function automatic int exp_wait(input logic [1:0] sp, input logic [10:0] a);
      logic [3:0] f;
      case (sp)
         2'd0: f = sh_prog;
         2'd1: f = sh_data;
         2'd2: f = sh_byte;
         default: f = sh_io[a[10:9]];
      endcase
      return sh_mode ? 2 * int'(f) + 1 : int'(f);
   endfunction

   task automatic check(input string tg, input logic [5:0] got, input logic [5:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", tg, got, exp);
      end
   endtask

   task automatic cfg_write(input logic [3:0] a, input logic [3:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
      if (a < 4) sh_io[a[1:0]] = d;
      else if (a == 4) sh_prog = d;
      else if (a == 5) sh_data = d;
      else if (a == 6) sh_byte = d;
      else if (a == 8) begin sh_mode = d[0]; sh_boff = d[1]; end
      else if (a == 9) sh_mask = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   // poke: inside the access, write a new value for the running region and
   // raise another request; neither may touch this access (R9, R10)
   task automatic access(input logic [1:0] sp, input logic [10:0] a, input string tg,
                         input bit poke = 1'b0, input logic [3:0] newv = 4'h0);
      int w;
      logic [3:0] es;
      logic       ec;
      w  = exp_wait(sp, a);
      es = (sp == 2'd2 && sh_boff) ? 4'hF : ~(4'b0001 << sp);
      ec = ~sh_mask[sp];
      @(negedge clk);
      req = 1'b1; space = sp; io_addr = a;
      for (int i = 0; i <= w; i++) begin
         exp_q.push_back({es, ec, (i == w)});
         tag_q.push_back(tg);
      end
      @(negedge clk);
      if (poke) begin
         space = 2'd3; io_addr = 11'h600;
         cfg_we = 1'b1; cfg_addr = {2'b00, a[10:9]}; cfg_data = newv;
         sh_io[a[10:9]] = newv;
         @(negedge clk);
         cfg_we = 1'b0;
      end
      req = 1'b0;
      repeat (w + (poke ? 0 : 1)) @(negedge clk);
   endtask

   // monitor: sample a quarter period after each rising edge
   initial begin
      logic [5:0] e;
      string      t;
      wait (rst_n);
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
         end else begin
            e = 6'b111111;
            t = "R1 idle/R11";
         end
         check(t, {sel_n, csel_n, ready}, e);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) sh_io[i] = 4'hF;
      repeat (3) @(negedge clk);
      check("R1 reset", {sel_n, csel_n, ready}, 6'b111111);
      rst_n = 1'b1;
      @(negedge clk);

      access(2'd3, 11'h000, "R1 reset field 15");
      access(2'd2, 11'h000, "R7 reset mask byte");
      cfg_write(4'd0, 4'd1);
      cfg_write(4'd1, 4'd2);
      cfg_write(4'd2, 4'd3);
      cfg_write(4'd3, 4'd4);
      cfg_write(4'd4, 4'd5);
      cfg_write(4'd5, 4'd6);
      cfg_write(4'd6, 4'd0);
      access(2'd3, 11'h1FF, "R2 region0");
      access(2'd3, 11'h200, "R2 region1");
      access(2'd3, 11'h5FF, "R2 region2");
      access(2'd3, 11'h600, "R2 region3");
      access(2'd3, 11'h7FF, "R3 region3 top");
      access(2'd0, 11'h000, "R5 program");
      access(2'd1, 11'h000, "R5 data");
      access(2'd2, 11'h000, "R3 zero waits byte");
      cfg_write(4'd8, 4'b0001);
      access(2'd3, 11'h000, "R4 double region0");
      access(2'd2, 11'h000, "R4 double zero");
      access(2'd1, 11'h000, "R4 double data");
      cfg_write(4'd8, 4'b0000);
      cfg_write(4'd9, 4'b0100);
      access(2'd2, 11'h000, "R6 mask byte only");
      access(2'd0, 11'h000, "R6 mask prog off");
      cfg_write(4'd9, 4'b1000);
      access(2'd3, 11'h400, "R6 mask io");
      cfg_write(4'd8, 4'b0010);
      access(2'd2, 11'h000, "R8 byte disabled masked off");
      cfg_write(4'd9, 4'b0100);
      access(2'd2, 11'h000, "R8 byte disabled composite");
      cfg_write(4'd6, 4'd2);
      access(2'd2, 11'h000, "R8 byte disabled waits");
      cfg_write(4'd8, 4'b0000);
      cfg_write(4'd9, 4'b1011);
      access(2'd3, 11'h2AA, "R9 R10 running access", 1'b1, 4'd5);
      access(2'd3, 11'h2AA, "R9 new value next access");

      repeat (3) @(negedge clk);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule